// File: doc/BRIEF.md
# Divide Register-Stack Sequencer

This block holds an eight-slot floating-point register stack with a rotating top pointer and an empty mark per slot. It runs the divide operation forms around an external divider. A decoded form code, a relative register index and an optional memory operand arrive with a one-cycle strobe. The block chooses which stack slot supplies the dividend, and whether the divisor comes from the stack or from the memory operand. It starts the divider with a single-cycle pulse and waits for the divider's completion. When the divider permits the write, it stores the quotient back into the destination slot. For the popping forms it then releases the top slot.

Stack slots are addressed relative to the top pointer. Relative slot k is physical slot (top + k) modulo the depth, so the depth must be a power of two. A separate load port pushes values onto the stack. The block does not decode instruction bytes, access memory or perform the division itself. Slot contents are opaque bit patterns.

Top module: `divstack_ctrl`

## Requirements
- R1: After reset the top pointer is 0, every slot is marked empty, `busy`, `divStart` and `stackFault` are low, and the first divide strobe reports a stack fault.
- R2: A `loadValid` pulse accepted while idle decrements the top pointer, writes `loadData` into the new relative slot 0 and clears its empty mark, so the previous relative slot k becomes slot k+1. Relative slot k is physical slot (top + k) mod 8.
- R3: Form code 0 divides relative slot 0 by `memOperand` and stores the quotient in slot 0.
- R4: Form code 1 divides slot 0 by slot `opIdx` and stores the quotient in slot 0.
- R5: Form code 2 divides slot `opIdx` by slot 0 and stores the quotient in slot `opIdx`.
- R6: Form code 3 behaves as form code 2 and then pops the stack.
- R7: Form code 4 divides slot 1 by slot 0, stores the quotient in slot 1 and always pops. `opIdx` is ignored.
- R8: A pop marks the slot that was relative slot 0 as empty and then increments the top pointer, so old slot 1 becomes slot 0.
- R9: When `divValid` arrives with `divWriteOk` low, the destination keeps its old value and no pop takes place.
- R10: If a stack operand is marked empty, `stackFault` pulses in the cycle after the strobe. No divider start, write or pop follows. The memory form checks only slot 0.
- R11: Once an operation is accepted, `divStart` pulses for exactly one cycle in the next cycle, with `divDividend` and `divDivisor` valid and held. `busy` stays high from that cycle until the cycle after `divValid`, and strobes and loads that arrive while `busy` is high are ignored.
- R12: Form codes 5 to 7 are ignored: they cause no start and no fault. A `loadValid` that arrives in the same cycle as an accepted divide strobe (form codes 0 to 4) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Divide operation strobe |
| opForm | input | 3 | Decoded form code (0 to 4 used) |
| opIdx | input | 3 | Relative register index i |
| memOperand | input | 32 | Divisor value for the memory form |
| loadValid | input | 1 | Push strobe |
| loadData | input | 32 | Value to push |
| busy | output | 1 | Operation in flight |
| stackFault | output | 1 | Empty-operand abort pulse |
| divStart | output | 1 | Divider start pulse |
| divDividend | output | 32 | Dividend to divider |
| divDivisor | output | 32 | Divisor to divider |
| divValid | input | 1 | Divider result valid |
| divQuotient | input | 32 | Divider result |
| divWriteOk | input | 1 | Divider permits the write-back |

## Verification
A wrong top pointer, a stale empty mark or a misdirected write does not appear at the ports right away. It shows up at the next operation that reads the affected slot: a wrong dividend or divisor is presented with `divStart`, or a `stackFault` pulse appears or goes missing one cycle after the strobe. The bench therefore follows every operation with later operations that read back the slots the previous one could have changed, across all forms, indices and both write-permit values. It tracks a model of the stack so that each corruption is caught at its first observable read.

// File: rtl/divstack_pkg.sv
package divstack_pkg;

  typedef enum logic [2:0] {
    FORM_MEM           = 3'd0,
    FORM_TOP_BY_REG    = 3'd1,
    FORM_REG_BY_TOP    = 3'd2,
    FORM_REG_BY_TOP_PP = 3'd3,
    FORM_ONE_BY_TOP_PP = 3'd4
  } form_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_e;

  typedef struct packed {
    logic latchOps;
    logic writeBack;
    logic popTop;
    logic pushTop;
  } strobe_t;

endpackage

// File: rtl/divstack_ctrl_fsm.sv
module divstack_ctrl_fsm
  import divstack_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opValid,
  input  logic [2:0]       opForm,
  input  logic [PTR_W-1:0] opIdx,
  input  logic             loadValid,
  input  logic             ddEmpty,
  input  logic             dsEmpty,
  input  logic             divValid,
  input  logic             divWriteOk,
  output logic [PTR_W-1:0] ddRel,
  output logic [PTR_W-1:0] dsRel,
  output logic [PTR_W-1:0] dstRel,
  output logic             useMem,
  output strobe_t          strb,
  output logic             busy,
  output logic             divStart,
  output logic             stackFault
);

  localparam logic [PTR_W-1:0] REL_ZERO = '0;
  localparam logic [PTR_W-1:0] REL_ONE  = PTR_W'(1);

  seq_e state;
  logic popPending;
  logic formLegal;
  logic formPops;
  logic take;
  logic faultNow;

  always_comb begin
    ddRel     = REL_ZERO;
    dsRel     = REL_ZERO;
    dstRel    = REL_ZERO;
    useMem    = 1'b0;
    formPops  = 1'b0;
    formLegal = 1'b1;
    case (form_e'(opForm))
      FORM_MEM: begin
        useMem = 1'b1;
      end
      FORM_TOP_BY_REG: begin
        dsRel = opIdx;
      end
      FORM_REG_BY_TOP: begin
        ddRel  = opIdx;
        dstRel = opIdx;
      end
      FORM_REG_BY_TOP_PP: begin
        ddRel    = opIdx;
        dstRel   = opIdx;
        formPops = 1'b1;
      end
      FORM_ONE_BY_TOP_PP: begin
        ddRel    = REL_ONE;
        dstRel   = REL_ONE;
        formPops = 1'b1;
      end
      default: formLegal = 1'b0;
    endcase
  end

  assign faultNow = ddEmpty | (~useMem & dsEmpty);
  assign take     = (state == SEQ_IDLE) & opValid & formLegal;

  always_comb begin
    strb.latchOps  = take & ~faultNow;
    strb.writeBack = (state == SEQ_WAIT) & divValid & divWriteOk;
    strb.popTop    = (state == SEQ_WAIT) & divValid & divWriteOk & popPending;
    strb.pushTop   = (state == SEQ_IDLE) & loadValid & ~take;
  end

  assign busy = (state == SEQ_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      popPending <= 1'b0;
      divStart   <= 1'b0;
      stackFault <= 1'b0;
    end else begin
      divStart   <= take & ~faultNow;
      stackFault <= take & faultNow;
      case (state)
        SEQ_IDLE: begin
          if (take && !faultNow) begin
            state      <= SEQ_WAIT;
            popPending <= formPops;
          end
        end
        SEQ_WAIT: begin
          if (divValid) begin
            state      <= SEQ_IDLE;
            popPending <= 1'b0;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/divstack_regfile.sv
module divstack_regfile
  import divstack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [PTR_W-1:0]  ddRel,
  input  logic [PTR_W-1:0]  dsRel,
  input  logic [PTR_W-1:0]  dstRel,
  input  logic              useMem,
  input  logic [DATA_W-1:0] memOperand,
  input  logic [DATA_W-1:0] loadData,
  input  logic [DATA_W-1:0] divQuotient,
  output logic              ddEmpty,
  output logic              dsEmpty,
  output logic [DATA_W-1:0] divDividend,
  output logic [DATA_W-1:0] divDivisor
);

  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  logic [DATA_W-1:0] slotData [DEPTH];
  logic [DEPTH-1:0]  slotEmpty;
  logic [PTR_W-1:0]  topQ;
  logic [PTR_W-1:0]  dstPhysQ;
  logic [PTR_W-1:0]  ddPhys;
  logic [PTR_W-1:0]  dsPhys;
  logic [PTR_W-1:0]  pushPhys;

  assign ddPhys   = topQ + ddRel;
  assign dsPhys   = topQ + dsRel;
  assign pushPhys = topQ - PTR_ONE;
  assign ddEmpty  = slotEmpty[ddPhys];
  assign dsEmpty  = slotEmpty[dsPhys];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      topQ      <= '0;
      slotEmpty <= '1;
      dstPhysQ  <= '0;
      for (int e = 0; e < DEPTH; e++) slotData[e] <= '0;
    end else begin
      if (strb.latchOps) dstPhysQ <= topQ + dstRel;
      if (strb.pushTop) begin
        topQ                <= pushPhys;
        slotData[pushPhys]  <= loadData;
        slotEmpty[pushPhys] <= 1'b0;
      end
      if (strb.writeBack) slotData[dstPhysQ] <= divQuotient;
      if (strb.popTop) begin
        slotEmpty[topQ] <= 1'b1;
        topQ            <= topQ + PTR_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divDividend <= '0;
      divDivisor  <= '0;
    end else if (strb.latchOps) begin
      divDividend <= slotData[ddPhys];
      divDivisor  <= useMem ? memOperand : slotData[dsPhys];
    end
  end

endmodule

// File: rtl/divstack_ctrl.sv
module divstack_ctrl
  import divstack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [2:0]        opForm,
  input  logic [PTR_W-1:0]  opIdx,
  input  logic [DATA_W-1:0] memOperand,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadData,
  output logic              busy,
  output logic              stackFault,
  output logic              divStart,
  output logic [DATA_W-1:0] divDividend,
  output logic [DATA_W-1:0] divDivisor,
  input  logic              divValid,
  input  logic [DATA_W-1:0] divQuotient,
  input  logic              divWriteOk
);

  strobe_t          strb;
  logic [PTR_W-1:0] ddRel;
  logic [PTR_W-1:0] dsRel;
  logic [PTR_W-1:0] dstRel;
  logic             useMem;
  logic             ddEmpty;
  logic             dsEmpty;

  divstack_ctrl_fsm #(.PTR_W(PTR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opForm(opForm), .opIdx(opIdx),
    .loadValid(loadValid), .ddEmpty(ddEmpty), .dsEmpty(dsEmpty),
    .divValid(divValid), .divWriteOk(divWriteOk), .ddRel(ddRel), .dsRel(dsRel),
    .dstRel(dstRel), .useMem(useMem), .strb(strb), .busy(busy),
    .divStart(divStart), .stackFault(stackFault)
  );

  divstack_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) data_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .ddRel(ddRel), .dsRel(dsRel),
    .dstRel(dstRel), .useMem(useMem), .memOperand(memOperand), .loadData(loadData),
    .divQuotient(divQuotient), .ddEmpty(ddEmpty), .dsEmpty(dsEmpty),
    .divDividend(divDividend), .divDivisor(divDivisor)
  );

endmodule

// File: rtl/divstack_ctrl_chk.sv
module divstack_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              stackFault,
  input logic              divStart,
  input logic              divValid,
  input logic [DATA_W-1:0] divDividend,
  input logic [DATA_W-1:0] divDivisor
);

  p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    divStart |=> !divStart);

  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    divStart |-> busy);

  p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !divValid) |=> busy);

  p_release_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && divValid) |=> !busy);

  p_operands_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !divStart) |-> ($stable(divDividend) && $stable(divDivisor)));

  p_fault_aborts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stackFault |-> (!busy && !divStart));

endmodule

bind divstack_ctrl divstack_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .stackFault(stackFault),
  .divStart(divStart), .divValid(divValid), .divDividend(divDividend),
  .divDivisor(divDivisor)
);

// File: tb/divstack_ctrl_tb_top.sv
module divstack_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        opValid, loadValid, divValid, divWriteOk;
  logic [2:0]  opForm, opIdx;
  logic [31:0] memOperand, loadData, divQuotient;
  logic        busy, stackFault, divStart;
  logic [31:0] divDividend, divDivisor;

  int nChk = 0;
  int nBad = 0;
  logic [31:0] mdl [8];
  bit   [7:0]  mtag;
  int          mtop;

  always #5 clk = ~clk;

  divstack_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opForm(opForm), .opIdx(opIdx),
    .memOperand(memOperand), .loadValid(loadValid), .loadData(loadData),
    .busy(busy), .stackFault(stackFault), .divStart(divStart),
    .divDividend(divDividend), .divDivisor(divDivisor), .divValid(divValid),
    .divQuotient(divQuotient), .divWriteOk(divWriteOk)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v);
    @(negedge clk);
    loadValid = 1'b1;
    loadData  = v;
    @(negedge clk);
    loadValid = 1'b0;
    mtop = (mtop + 7) & 7;
    mdl[mtop] = v;
    mtag[mtop] = 1'b0;
  endtask

  task automatic runOp(input int form, input int idx, input logic [31:0] mem,
                       input bit wok, input bit withLoad);
    int ddR, dsR, dstR;
    bit pops, useM, legal, fault;
    logic [31:0] dd, ds, q;
    string req;
    ddR = 0; dsR = 0; dstR = 0; pops = 0; useM = 0; legal = 1;
    case (form)
      0: begin useM = 1; req = "R3"; end
      1: begin dsR = idx; req = "R4"; end
      2: begin ddR = idx; dstR = idx; req = "R5"; end
      3: begin ddR = idx; dstR = idx; pops = 1; req = "R6"; end
      4: begin ddR = 1; dstR = 1; pops = 1; req = "R7"; end
      default: begin legal = 0; req = "R12"; end
    endcase
    @(negedge clk);
    opValid = 1'b1; opForm = 3'(form); opIdx = 3'(idx); memOperand = mem;
    loadValid = withLoad; loadData = 32'hDEAD0000 + 32'(idx);
    @(negedge clk);
    opValid = 1'b0; loadValid = 1'b0;
    if (!legal) begin
      chk(divStart == 1'b0, "R12", "reserved form started", 32'(divStart), 0);
      chk(stackFault == 1'b0, "R12", "reserved form faulted", 32'(stackFault), 0);
      return;
    end
    fault = mtag[(mtop + ddR) & 7] | (!useM & mtag[(mtop + dsR) & 7]);
    if (fault) begin
      chk(stackFault == 1'b1, "R10", "fault pulse", 32'(stackFault), 1);
      chk(divStart == 1'b0 && busy == 1'b0, "R10", "start/busy on fault",
          {30'd0, divStart, busy}, 0);
      return;
    end
    dd = mdl[(mtop + ddR) & 7];
    ds = useM ? mem : mdl[(mtop + dsR) & 7];
    chk(divStart == 1'b1 && stackFault == 1'b0, "R11", "start pulse",
        {30'd0, divStart, stackFault}, 2);
    chk(divDividend == dd, req, "dividend (state R2 R8 R9)", divDividend, dd);
    chk(divDivisor == ds, req, "divisor (state R2 R8 R9)", divDivisor, ds);
    @(negedge clk);
    chk(divStart == 1'b0 && busy == 1'b1, "R11", "single pulse while busy",
        {30'd0, divStart, busy}, 1);
    opValid = 1'b1; opForm = 3'd1; opIdx = 3'd0; loadValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0; loadValid = 1'b0;
    chk(divStart == 1'b0 && stackFault == 1'b0, "R11", "strobe ignored while busy",
        {30'd0, divStart, stackFault}, 0);
    q = dd * 32'd3 + ds;
    divValid = 1'b1; divQuotient = q; divWriteOk = wok;
    @(negedge clk);
    divValid = 1'b0;
    chk(busy == 1'b0, "R11", "busy release", 32'(busy), 0);
    if (wok) begin
      mdl[(mtop + dstR) & 7] = q;
      if (pops) begin
        mtag[mtop] = 1'b1;
        mtop = (mtop + 1) & 7;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int it;
    rst_n = 1'b0; opValid = 0; loadValid = 0; divValid = 0; divWriteOk = 0;
    opForm = 0; opIdx = 0; memOperand = 0; loadData = 0; divQuotient = 0;
    mtop = 0; mtag = '1;
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && divStart == 0 && stackFault == 0, "R1", "reset outputs",
        {29'd0, busy, divStart, stackFault}, 0);
    runOp(1, 0, 32'h0, 1'b1, 1'b0);   // R1: all slots empty after reset

    // R2, R8, R9: directed push, suppressed pop, real pop
    push(32'h0000_1111);
    push(32'h0000_2222);
    runOp(4, 5, 32'h0, 1'b0, 1'b0);   // R9: no write, no pop
    runOp(1, 1, 32'h0, 1'b0, 1'b0);   // R2: slot1 is the older value
    runOp(4, 0, 32'h0, 1'b1, 1'b0);   // R7 then R8 pop
    runOp(1, 1, 32'h0, 1'b0, 1'b0);   // R8: slot1 now empty -> fault
    runOp(0, 0, 32'h0000_0005, 1'b1, 1'b0);
    runOp(7, 0, 32'h0, 1'b1, 1'b0);   // R12 reserved

    it = 0;
    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < 8; i++) begin
        for (int w = 0; w < 2; w++) begin
          if ((it % 3) == 0) push(32'(it) * 32'h0101_0101 + 32'd7);
          runOp(f, i, 32'h4000_0000 + 32'(it), w[0], (f < 5) && ((it % 7) == 3));
          it++;
        end
      end
    end
    for (int k = 0; k < 8; k++) runOp(1, k, 32'h0, 1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule